// File: doc/BRIEF.md
# Performance Monitoring Counter Unit

This block counts processor activity for profiling. It holds five counters: four event counters and one cycle counter. Each event counter follows one line of an input event vector. The line is picked by an 8-bit selector. The cycle counter counts clocks, either every clock or once per 64 clocks through a prescaler.

Software drives the block through a small register port. The port writes control, selection, interrupt enable and flag state, and it preloads any counter. A counter wraps from all-ones to zero and raises its overflow flag at that moment. Software can preload a counter close to all-ones so that it overflows after a chosen number of increments, which is the basis for sampling. A single interrupt line is high while any overflow flag is set and its matching enable bit is also set.

Top module: `perf_mon_unit`

## Requirements
- R1: After reset every register reads 0 and irq is low.
- R2: Control bit 0 starts all five counters together. Writing 0 to it stops all five counters, and they hold their values.
- R3: Writing 1 to control bit 1 clears event counters 0 to 3 in the same edge. The cycle counter is not changed. Control bits 1 and 2 always read back as 0.
- R4: Writing 1 to control bit 2 clears only the cycle counter. The event counters keep their values.
- R5: When control bit 3 is set, the cycle counter advances once every 64 clocks. A cycle counter clear also restarts the prescaler, so after the clear the first step lands on the 64th enabled clock.
- R6: The event select register (address 1) holds one byte per event counter: bits 8k+7:8k belong to counter k. A selector value v below the event vector width makes counter k add one on each enabled clock where evt_in[v] is high.
- R7: A selector of 0xFF, or any value not below the event vector width, counts nothing.
- R8: Register map: 0 control, 1 event select, 2 overflow flags, 3 interrupt enables, 4 cycle counter, 5 to 8 event counters 0 to 3. Writing address 4 to 8 preloads that counter.
- R9: A counter that increments from 0xFFFFFFFF becomes 0 and sets its flag in the same edge. The flag and enable layout is: bit 0 is the cycle counter, and bits 1 to 4 are event counters 0 to 3.
- R10: Overflow flags clear on a write of 1 to the bit. A written 0 leaves the bit unchanged.
- R11: irq is high exactly while some flag bit and the same interrupt enable bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| evt_in | input | EVT_W | Event lines, one clock per occurrence |
| irq | output | 1 | Overflow interrupt |

## Verification
The assertions assume a few things about the inputs:
- A write strobe and its address are settled before the clock edge.
- evt_in is synchronous to clk.
- EVT_W stays below 255, so 0xFF can never name a real line.

The stimulus drives every input on the falling edge. It reads registers only while the counters are stopped, except where a check is designed around a running count.

// File: rtl/perf_mon_pkg.sv
package perf_mon_pkg;
  localparam int NUM_EVT = 4;
  localparam int NUM_CNT = NUM_EVT + 1;
  localparam int CYC_ID  = NUM_EVT;
  localparam int SEL_W   = 8;
  localparam int ADDR_W  = 4;

  localparam logic [ADDR_W-1:0] A_CTRL = 4'd0;
  localparam logic [ADDR_W-1:0] A_SEL  = 4'd1;
  localparam logic [ADDR_W-1:0] A_FLAG = 4'd2;
  localparam logic [ADDR_W-1:0] A_IEN  = 4'd3;
  localparam logic [ADDR_W-1:0] A_CYC  = 4'd4;
  localparam logic [ADDR_W-1:0] A_EVT0 = 4'd5;

  // control bit positions
  localparam int C_RUN    = 0;
  localparam int C_EVTCLR = 1;
  localparam int C_CYCCLR = 2;
  localparam int C_DIV    = 3;

  // position of counter id in the shared flag/enable layout
  function automatic int flag_pos(input int id);
    return (id == CYC_ID) ? 0 : id + 1;
  endfunction
endpackage

// File: rtl/pm_prescaler.sv
module pm_prescaler #(
  parameter int DIV_RATIO = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clr,
  output logic tick
);
  localparam int PW = (DIV_RATIO > 1) ? $clog2(DIV_RATIO) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV_RATIO - 1);

  logic [PW-1:0] pcnt_q;

  assign tick = run && (pcnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pcnt_q <= '0;
    else if (clr)  pcnt_q <= '0;
    else if (run)  pcnt_q <= tick ? '0 : pcnt_q + 1'b1;
  end

  // R5
  tick_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> pcnt_q == '0);
endmodule

// File: rtl/pm_counter.sv
module pm_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         clr,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  function automatic logic [W-1:0] bump(input logic [W-1:0] v);
    return v + 1'b1;
  endfunction

  logic [W-1:0] cnt_q;

  assign cnt  = cnt_q;
  assign wrap = inc && !clr && !ld && (cnt_q == '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clr)   cnt_q <= '0;
    else if (ld)    cnt_q <= ld_val;
    else if (inc)   cnt_q <= bump(cnt_q);
  end

  // R9
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> cnt_q == '0);
  // R8
  preload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && !clr) |=> cnt_q == $past(ld_val));
endmodule

// File: rtl/perf_mon_unit.sv
module perf_mon_unit
  import perf_mon_pkg::*;
#(
  parameter int EVT_W     = 16,
  parameter int CNT_W     = 32,
  parameter int DIV_RATIO = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [CNT_W-1:0]   reg_wdata,
  output logic [CNT_W-1:0]   reg_rdata,
  input  logic [EVT_W-1:0]   evt_in,
  output logic               irq
);
  localparam int SELV_W = SEL_W * NUM_EVT;

  function automatic logic sel_hit(input logic [SEL_W-1:0] s, input logic [EVT_W-1:0] ev);
    logic h;
    h = 1'b0;
    for (int i = 0; i < EVT_W; i++)
      if (s == SEL_W'(i)) h = ev[i];
    return h;
  endfunction

  logic               run_q, div_q;
  logic [SELV_W-1:0]  sel_q;
  logic [NUM_CNT-1:0] ien_q, flag_q;

  logic ctrl_wr, flag_wr, evt_clr, cyc_clr, tick;
  logic [NUM_CNT-1:0] inc, clr, ld, wrap, ovf_map;
  logic [CNT_W-1:0]   cnt [NUM_CNT];

  assign ctrl_wr = reg_wr && (reg_addr == A_CTRL);
  assign flag_wr = reg_wr && (reg_addr == A_FLAG);
  assign evt_clr = ctrl_wr && reg_wdata[C_EVTCLR];
  assign cyc_clr = ctrl_wr && reg_wdata[C_CYCCLR];

  pm_prescaler #(.DIV_RATIO(DIV_RATIO)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run_q && div_q), .clr(cyc_clr), .tick(tick)
  );

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
    if (k == CYC_ID) begin : g_cyc
      assign inc[k] = run_q && (!div_q || tick);
      assign clr[k] = cyc_clr;
      assign ld[k]  = reg_wr && (reg_addr == A_CYC);
    end else begin : g_evt
      assign inc[k] = run_q && sel_hit(sel_q[k*SEL_W +: SEL_W], evt_in);
      assign clr[k] = evt_clr;
      assign ld[k]  = reg_wr && (reg_addr == A_EVT0 + ADDR_W'(k));
      // R7
      idle_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q[k*SEL_W +: SEL_W] == 8'hFF && !ld[k] && !clr[k]) |=> $stable(cnt[k]));
    end
    assign ovf_map[flag_pos(k)] = wrap[k];

    pm_counter #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .inc(inc[k]), .clr(clr[k]), .ld(ld[k]),
      .ld_val(reg_wdata), .cnt(cnt[k]), .wrap(wrap[k])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      div_q  <= 1'b0;
      sel_q  <= '0;
      ien_q  <= '0;
      flag_q <= '0;
    end else begin
      if (ctrl_wr) begin
        run_q <= reg_wdata[C_RUN];
        div_q <= reg_wdata[C_DIV];
      end
      if (reg_wr && reg_addr == A_SEL) sel_q <= reg_wdata[SELV_W-1:0];
      if (reg_wr && reg_addr == A_IEN) ien_q <= reg_wdata[NUM_CNT-1:0];
      flag_q <= ovf_map | (flag_q & ~(flag_wr ? reg_wdata[NUM_CNT-1:0] : '0));
    end
  end

  assign irq = |(flag_q & ien_q);

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL: begin
        reg_rdata[C_RUN] = run_q;
        reg_rdata[C_DIV] = div_q;
      end
      A_SEL:  reg_rdata = CNT_W'(sel_q);
      A_FLAG: reg_rdata = CNT_W'(flag_q);
      A_IEN:  reg_rdata = CNT_W'(ien_q);
      A_CYC:  reg_rdata = cnt[CYC_ID];
      default: begin
        for (int k = 0; k < NUM_EVT; k++)
          if (reg_addr == A_EVT0 + ADDR_W'(k)) reg_rdata = cnt[k];
      end
    endcase
  end

  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !reg_wr) |=> $stable(cnt[CYC_ID]) && $stable(cnt[0]));
  // R10
  flag_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_wr && reg_wdata[0] && !wrap[CYC_ID]) |=> !flag_q[0]);
  // R11
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap[CYC_ID] && ien_q[0] && !(reg_wr && reg_addr == A_IEN)) |=> irq);
endmodule

// File: tb/perf_mon_unit_bench.sv
module perf_mon_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [15:0] evt_in = '0;
  logic        irq;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  perf_mon_unit u_perf_mon_unit (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_in(evt_in), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int a = 0; a < 9; a++) begin
      rd(4'(a), v);
      chk("R1 reg after reset", v, 32'h0);
    end
    chk("R1 irq after reset", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_run_stop;
    logic [31:0] v;
    wr(4'd0, 32'h5);             // run + cycle clear
    repeat (20) @(posedge clk);
    wr(4'd0, 32'h0);             // one more enabled edge, then stop
    repeat (10) @(posedge clk);
    rd(4'd4, v);
    chk("R2 cycle count stops at 21", v, 32'd21);
    rd(4'd0, v);
    chk("R2 control reads 0 after stop", v, 32'h0);
  endtask

  task automatic t_clears;
    logic [31:0] v;
    wr(4'd5, 32'd123);
    wr(4'd8, 32'd55);
    wr(4'd0, 32'h2);             // event clear only
    rd(4'd5, v); chk("R3 event 0 cleared", v, 32'h0);
    rd(4'd8, v); chk("R3 event 3 cleared", v, 32'h0);
    rd(4'd4, v); chk("R3 cycle untouched", v, 32'd21);
    rd(4'd0, v); chk("R3 clear bits read 0", v, 32'h0);
    wr(4'd6, 32'd77);
    wr(4'd0, 32'h4);             // cycle clear only
    rd(4'd4, v); chk("R4 cycle cleared", v, 32'h0);
    rd(4'd6, v); chk("R4 event 1 kept", v, 32'd77);
  endtask

  task automatic t_divider;
    logic [31:0] v;
    wr(4'd0, 32'hD);             // run, cycle clear, divider
    repeat (130) @(posedge clk);
    wr(4'd0, 32'h0);
    rd(4'd4, v);
    chk("R5 divided cycle count", v, 32'd2);
    rd(4'd0, v);
    chk("R5 divider bit cleared by write", v, 32'h0);
  endtask

  task automatic t_select;
    logic [31:0] v;
    wr(4'd1, 32'h05_14_FF_02);   // c0=line2, c1=none, c2=line20, c3=line5
    rd(4'd1, v); chk("R8 select readback", v, 32'h0514FF02);
    wr(4'd0, 32'h3);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      evt_in = 16'h0004 | ((i % 2 == 1) ? 16'h0020 : 16'h0) | 16'h0002;
      @(posedge clk);
    end
    @(negedge clk); evt_in = '0;
    wr(4'd0, 32'h0);
    rd(4'd5, v); chk("R6 counter 0 on line 2", v, 32'd10);
    rd(4'd8, v); chk("R6 counter 3 on line 5", v, 32'd5);
    rd(4'd6, v); chk("R7 selector FF counts nothing", v, 32'd0);
    rd(4'd7, v); chk("R7 out-of-range selector counts nothing", v, 32'd0);
  endtask

  task automatic t_overflow;
    logic [31:0] v;
    wr(4'd1, 32'hFFFF00FF);      // only counter 1 on line 0
    wr(4'd4, 32'hFFFFFFFF);
    wr(4'd6, 32'hFFFFFFFE);
    @(negedge clk); evt_in = 16'h0001;
    wr(4'd0, 32'h1);
    repeat (2) @(posedge clk);
    wr(4'd0, 32'h0);
    @(negedge clk); evt_in = '0;
    rd(4'd2, v); chk("R9 flags cycle bit0 and event1 bit2", v, 32'h5);
    rd(4'd4, v); chk("R9 cycle wrapped", v, 32'd2);
    rd(4'd6, v); chk("R9 event 1 wrapped", v, 32'd1);
    chk("R11 irq low with no enables", {31'b0, irq}, 32'h0);
    wr(4'd3, 32'h04);
    chk("R11 irq from event 1 flag", {31'b0, irq}, 32'h1);
    wr(4'd3, 32'h01);
    chk("R11 irq from cycle flag", {31'b0, irq}, 32'h1);
    wr(4'd2, 32'h01);
    rd(4'd2, v); chk("R10 W1C clears bit 0 only", v, 32'h4);
    chk("R11 irq drops when enabled flag clears", {31'b0, irq}, 32'h0);
    wr(4'd2, 32'h00);
    rd(4'd2, v); chk("R10 zero write keeps flags", v, 32'h4);
    wr(4'd2, 32'h04);
    rd(4'd2, v); chk("R10 all flags cleared", v, 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_run_stop();
    t_clears();
    t_divider();
    t_select();
    t_overflow();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule